// File: doc/BRIEF.md
# Programmable Routing Switch Box

This block sits where a horizontal routing channel crosses a vertical one. Each of its four sides (north, east, south, west) carries a bundle of `W` tracks. Every physical wire is modelled as an input port and an output port on its side. An incoming track can be linked to exactly one track on each of the other three sides, so every track has a fan-out of three possible links. Each link has its own configuration flip-flop. All of these flip-flops form one serial shift chain, which is loaded one bit per clock.

A build-time parameter picks the link pattern. In subset mode, track `k` only meets track `k` on the other sides. In rotated mode, turning links join tracks at different indices, so a route can change lanes as it turns. Straight-through links keep their index in both modes. Each output track is the logical OR of the enabled links that land on it. A configuration that lands two or more enabled links on one output track raises a conflict flag. While the chain is being loaded, every output track and the conflict flag are held low.

Top module: `route_switch_box`

## Requirements
- R1: After reset every link is disabled: all output tracks read 0 for any input values, `conflict` is 0 and `cfg_out` is 0.
- R2: Links are numbered `index = (side*W + track)*3 + turn`, with side north=0, east=1, south=2, west=3 for the link's source side. Turn 0 goes to side `(side+1) mod 4`, turn 1 to `(side+2) mod 4` and turn 2 to `(side+3) mod 4`. Each rising edge with `cfg_en` high shifts `cfg_in` into index `12W-1` and moves every stored bit down by one index. After `12W` shifts, the first bit sent sits at index 0.
- R3: `cfg_out` always shows the bit stored at index 0, so a loaded pattern leaves the chain index 0 first while the next pattern is shifted in.
- R4: While `cfg_en` is low the stored configuration does not change, whatever `cfg_in` does.
- R5: While `cfg_en` is high all output tracks and `conflict` are 0.
- R6: With `TOPOLOGY=0` (subset), an enabled link from track k always reaches track k on its destination side.
- R7: With `TOPOLOGY=1` (rotated), straight links keep the index. Turning links map source track k as follows: west→north and north→west go to (W-k) mod W; north→east and south→west go to (k+1) mod W; east→north and west→south go to (k+W-1) mod W; east→south and south→east go to (2W-2-k) mod W.
- R8: Each output track is the OR of the input tracks whose links onto it are enabled. Disabled links and undriven tracks have no effect. Outputs follow inputs within the same cycle, and a new configuration takes effect as soon as `cfg_en` falls.
- R9: `conflict` is 1 exactly when `cfg_en` is low and some output track has two or more enabled links onto it. The flag depends on the configuration only, never on track data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain |
| rst_n | input | 1 | Asynchronous active-low reset, clears all links |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_in | input | 1 | Serial configuration data in |
| cfg_out | output | 1 | Serial configuration data out (index 0) |
| north_in | input | W | Tracks arriving on the north side |
| east_in | input | W | Tracks arriving on the east side |
| south_in | input | W | Tracks arriving on the south side |
| west_in | input | W | Tracks arriving on the west side |
| north_out | output | W | Tracks leaving on the north side |
| east_out | output | W | Tracks leaving on the east side |
| south_out | output | W | Tracks leaving on the south side |
| west_out | output | W | Tracks leaving on the west side |
| conflict | output | 1 | More than one enabled link lands on some output track |

## Verification
Track outputs and `conflict` are combinational. Each one is due in the cycle its inputs change, so the bench drives inputs just after a falling edge and samples one time unit later, before the next rising edge. A configuration bit moves one chain position per rising edge with `cfg_en` high. The bench therefore checks `cfg_out` on the falling edge ahead of each shift, and checks link behaviour on the falling edge where `cfg_en` has just dropped. Two instances, one per topology, share the same stimulus and configuration stream. Every single-link configuration is swept for both.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

  localparam int SIDES = 4;
  localparam int TURNS = 3;

  localparam int SIDE_N = 0;
  localparam int SIDE_E = 1;
  localparam int SIDE_S = 2;
  localparam int SIDE_W = 3;

  localparam int TOPO_SUBSET  = 0;
  localparam int TOPO_ROTATED = 1;

  // side reached from source side s by turn t
  function automatic int dest_side(input int s, input int t);
    return (s + 1 + t) % SIDES;
  endfunction

  // turn number that carries source side s onto side d (d != s)
  function automatic int turn_of(input int s, input int d);
    return (d - s + SIDES - 1) % SIDES;
  endfunction

  // destination track index for source track k going from side s to side d
  function automatic int track_map(input int topo, input int s, input int d,
                                   input int k, input int w);
    int r;
    r = k;
    if (topo == TOPO_ROTATED) begin
      if (s == SIDE_W && d == SIDE_N) r = (w - k) % w;
      else if (s == SIDE_N && d == SIDE_W) r = (w - k) % w;
      else if (s == SIDE_N && d == SIDE_E) r = (k + 1) % w;
      else if (s == SIDE_E && d == SIDE_N) r = (k + w - 1) % w;
      else if (s == SIDE_E && d == SIDE_S) r = (2 * w - 2 - k) % w;
      else if (s == SIDE_S && d == SIDE_E) r = (2 * w - 2 - k) % w;
      else if (s == SIDE_S && d == SIDE_W) r = (k + 1) % w;
      else if (s == SIDE_W && d == SIDE_S) r = (k + w - 1) % w;
      else r = k;
    end
    return r;
  endfunction

  // inverse of track_map: which source track on side s lands on track j of side d
  function automatic int track_src(input int topo, input int s, input int d,
                                   input int j, input int w);
    int r;
    r = 0;
    for (int k = 0; k < w; k++) begin
      if (track_map(topo, s, d, k, w) == j) r = k;
    end
    return r;
  endfunction

  // position of a link inside the configuration chain
  function automatic int link_index(input int s, input int k, input int t,
                                    input int w);
    return (s * w + k) * TURNS + t;
  endfunction

endpackage

// File: rtl/rsb_cfg_chain.sv
module rsb_cfg_chain #(
  parameter int NBITS = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             ser_in,
  output logic             ser_out,
  output logic [NBITS-1:0] bits_o
);

  logic [NBITS-1:0] store_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
    end else if (shift_en) begin
      store_q <= {ser_in, store_q[NBITS-1:1]};
    end
  end

  assign bits_o  = store_q;
  assign ser_out = store_q[0];

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (store_q == '0 && !ser_out));

  assert_load_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> store_q[NBITS-1] == $past(ser_in));

  assert_tail_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> ser_out == $past(store_q[1]));

  assert_chain_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(store_q));

endmodule

// File: rtl/rsb_track_merge.sv
module rsb_track_merge #(
  parameter int NSRC = 3
) (
  input  logic [NSRC-1:0] dat_i,
  input  logic [NSRC-1:0] en_i,
  input  logic            quiet_i,
  output logic            trk_o,
  output logic            clash_o
);

  logic [NSRC-1:0] live;
  logic            multi;

  assign live = dat_i & en_i;

  always_comb begin
    int n;
    n = 0;
    for (int i = 0; i < NSRC; i++) begin
      n = n + int'(en_i[i]);
    end
    multi = (n >= 2);
  end

  assign trk_o   = (|live) & ~quiet_i;
  assign clash_o = multi & ~quiet_i;

endmodule

// File: rtl/route_switch_box.sv
module route_switch_box #(
  parameter int W        = 4,
  parameter int TOPOLOGY = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_en,
  input  logic         cfg_in,
  output logic         cfg_out,
  input  logic [W-1:0] north_in,
  input  logic [W-1:0] east_in,
  input  logic [W-1:0] south_in,
  input  logic [W-1:0] west_in,
  output logic [W-1:0] north_out,
  output logic [W-1:0] east_out,
  output logic [W-1:0] south_out,
  output logic [W-1:0] west_out,
  output logic         conflict
);
  import rsb_pkg::*;

  localparam int NLINK  = SIDES * W * TURNS;
  localparam int NTRACK = SIDES * W;

  logic [NLINK-1:0]  link_en;
  logic [NTRACK-1:0] in_all;
  logic [NTRACK-1:0] out_all;
  logic [NTRACK-1:0] clash_all;

  assign in_all = {west_in, south_in, east_in, north_in};

  rsb_cfg_chain #(.NBITS(NLINK)) chain_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(cfg_en),
    .ser_in  (cfg_in),
    .ser_out (cfg_out),
    .bits_o  (link_en)
  );

  for (genvar d = 0; d < SIDES; d++) begin : g_side
    for (genvar j = 0; j < W; j++) begin : g_trk
      logic [TURNS-1:0] cand_dat;
      logic [TURNS-1:0] cand_en;
      for (genvar u = 0; u < TURNS; u++) begin : g_src
        localparam int SRC_SIDE = (d + 1 + u) % SIDES;
        localparam int SRC_TRK  = track_src(TOPOLOGY, SRC_SIDE, d, j, W);
        localparam int SRC_TURN = turn_of(SRC_SIDE, d);
        localparam int LINK_IDX = link_index(SRC_SIDE, SRC_TRK, SRC_TURN, W);
        assign cand_dat[u] = in_all[SRC_SIDE*W + SRC_TRK];
        assign cand_en[u]  = link_en[LINK_IDX];
      end
      rsb_track_merge #(.NSRC(TURNS)) merge_i (
        .dat_i  (cand_dat),
        .en_i   (cand_en),
        .quiet_i(cfg_en),
        .trk_o  (out_all[d*W + j]),
        .clash_o(clash_all[d*W + j])
      );
    end
  end

  assign north_out = out_all[SIDE_N*W +: W];
  assign east_out  = out_all[SIDE_E*W +: W];
  assign south_out = out_all[SIDE_S*W +: W];
  assign west_out  = out_all[SIDE_W*W +: W];
  assign conflict  = |clash_all;

  assert_quiet_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |-> (out_all == '0 && !conflict));

  assert_no_stray_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_all == '0) |-> (out_all == '0));

  assert_conflict_data_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && $past(!cfg_en)) |-> $stable(conflict));

endmodule

// File: tb/route_switch_box_tb.sv
module route_switch_box_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W  = 4;
  localparam int NB = 12 * W;
  localparam int NT = 4 * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b0;
  logic cfg_in = 1'b0;
  logic [NT-1:0] din = '0;

  logic          cfg_out_r, cfg_out_p, conf_r, conf_p;
  logic [W-1:0]  n_r, e_r, s_r, w_r, n_p, e_p, s_p, w_p;
  logic [NT-1:0] out_r, out_p;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  route_switch_box #(.W(W), .TOPOLOGY(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_in(cfg_in), .cfg_out(cfg_out_r),
    .north_in(din[0 +: W]), .east_in(din[W +: W]), .south_in(din[2*W +: W]),
    .west_in(din[3*W +: W]),
    .north_out(n_r), .east_out(e_r), .south_out(s_r), .west_out(w_r),
    .conflict(conf_r)
  );

  route_switch_box #(.W(W), .TOPOLOGY(0)) dut_pl_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_in(cfg_in), .cfg_out(cfg_out_p),
    .north_in(din[0 +: W]), .east_in(din[W +: W]), .south_in(din[2*W +: W]),
    .west_in(din[3*W +: W]),
    .north_out(n_p), .east_out(e_p), .south_out(s_p), .west_out(w_p),
    .conflict(conf_p)
  );

  assign out_r = {w_r, s_r, e_r, n_r};
  assign out_p = {w_p, s_p, e_p, n_p};

  // bench restatement of the R6/R7 lane mapping, keyed on source*4+dest
  function automatic int lane(int topo, int s, int d, int k);
    if (topo == 0 || (s ^ d) == 2) return k;
    case (s * 4 + d)
      12, 3:  return (W - k) % W;
      1, 11:  return (k + 1) % W;
      4, 14:  return (k + W - 1) % W;
      6, 9:   return (2 * W - 2 - k) % W;
      default: return -1;
    endcase
  endfunction

  function automatic logic [NT-1:0] model_out(int topo, logic [NB-1:0] c, logic [NT-1:0] x);
    logic [NT-1:0] r;
    int idx;
    r = '0;
    idx = 0;
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < W; k++)
        for (int t = 0; t < 3; t++) begin
          int d;
          d = (s + 1 + t) % 4;
          if (c[idx] && x[s*W + k]) r[d*W + lane(topo, s, d, k)] = 1'b1;
          idx++;
        end
    return r;
  endfunction

  function automatic logic model_conf(int topo, logic [NB-1:0] c);
    int cnt [NT];
    int idx;
    logic r;
    for (int i = 0; i < NT; i++) cnt[i] = 0;
    idx = 0;
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < W; k++)
        for (int t = 0; t < 3; t++) begin
          int d;
          d = (s + 1 + t) % 4;
          if (c[idx]) cnt[d*W + lane(topo, s, d, k)]++;
          idx++;
        end
    r = 1'b0;
    for (int i = 0; i < NT; i++) if (cnt[i] > 1) r = 1'b1;
    return r;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // shift a full pattern; index 0 is sent first (R2). Returns with cfg_en low.
  task automatic load(logic [NB-1:0] v);
    for (int i = 0; i < NB; i++) begin
      @(negedge clk);
      cfg_en = 1'b1;
      cfg_in = v[i];
    end
    @(negedge clk);
    cfg_en = 1'b0;
    cfg_in = 1'b0;
    #1;
  endtask

  task automatic apply_and_check(string req, logic [NB-1:0] c, logic [NT-1:0] x);
    din = x;
    #1;
    chk({req, " subset out"},  64'(out_p), 64'(model_out(0, c, x)));
    chk({req, " rotated out"}, 64'(out_r), 64'(model_out(1, c, x)));
    chk({req, " subset conflict R9"},  64'(conf_p), 64'(model_conf(0, c)));
    chk({req, " rotated conflict R9"}, 64'(conf_r), 64'(model_conf(1, c)));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    if (!done) begin
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [NB-1:0] cfg, cfg_b;
    logic [NT-1:0] x;
    logic [15:0] lfsr;
    lfsr = 16'hACE1;

    // R1: reset state
    din = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 rotated out", 64'(out_r), 64'(0));
    chk("R1 subset out",  64'(out_p), 64'(0));
    chk("R1 conflict",    64'({conf_r, conf_p}), 64'(0));
    chk("R1 cfg_out",     64'({cfg_out_r, cfg_out_p}), 64'(0));

    // R5: outputs quiet while loading an all-links pattern with busy inputs
    din = '1;
    for (int i = 0; i < NB; i++) begin
      @(negedge clk);
      cfg_en = 1'b1;
      cfg_in = 1'b1;
      #1;
      if (i % 8 == 7) begin
        chk("R5 rotated out quiet", 64'(out_r), 64'(0));
        chk("R5 subset out quiet",  64'(out_p), 64'(0));
        chk("R5 conflict quiet",    64'({conf_r, conf_p}), 64'(0));
      end
    end
    @(negedge clk);
    cfg_en = 1'b0;
    #1;
    // R8: new configuration active as soon as cfg_en falls
    apply_and_check("R8 all links", '1, '1);

    // R2/R6/R7/R8: every single link, for both topologies
    for (int i = 0; i < NB; i++) begin
      int s, k;
      cfg = '0;
      cfg[i] = 1'b1;
      load(cfg);
      s = i / (3 * W);
      k = (i / 3) % W;
      x = '0;
      x[s*W + k] = 1'b1;
      apply_and_check("R2 R6 R7 single link driven", cfg, x);
      apply_and_check("R8 single link other tracks", cfg, ~x);
    end

    // R9: two links on one output (north k0 straight + east k0 turn 0)
    cfg = '0;
    cfg[(0*W + 0)*3 + 1] = 1'b1;
    cfg[(1*W + 0)*3 + 0] = 1'b1;
    load(cfg);
    apply_and_check("R9 shared south k0", cfg, '0);
    chk("R9 subset clash expected", 64'(conf_p), 64'(1));
    chk("R9 rotated no clash",      64'(conf_r), 64'(0));
    cfg = '0;
    cfg[(0*W + 3)*3 + 1] = 1'b1;
    cfg[(1*W + 3)*3 + 0] = 1'b1;
    load(cfg);
    apply_and_check("R9 shared south k3", cfg, '1);
    chk("R9 both clash", 64'({conf_r, conf_p}), 64'(3));

    // R8/R9: OR of enabled drivers under many data patterns
    for (int p = 0; p < 3; p++) begin
      if (p == 0) cfg = '1;
      else begin
        for (int b = 0; b < NB; b++) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          cfg[b] = lfsr[0] & lfsr[3];
        end
      end
      load(cfg);
      for (int v = 0; v < 24; v++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        apply_and_check("R8 mixed data", cfg, NT'(lfsr ^ 16'(v * 37)));
      end
    end

    // R4: cfg_in activity with cfg_en low leaves configuration intact
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      cfg_in = ~cfg_in;
    end
    @(negedge clk);
    cfg_in = 1'b0;
    #1;
    apply_and_check("R4 held config", cfg, '1);
    apply_and_check("R4 held config 2", cfg, NT'(16'h5A3C));

    // R3: old pattern leaves through cfg_out, index 0 first, while a new one enters
    cfg_b = '0;
    for (int b = 0; b < NB; b++) cfg_b[b] = b[0] ^ b[2];
    for (int i = 0; i < NB; i++) begin
      @(negedge clk);
      #1;
      chk("R3 cfg_out stream rotated", 64'(cfg_out_r), 64'(cfg[i]));
      chk("R3 cfg_out stream subset",  64'(cfg_out_p), 64'(cfg[i]));
      cfg_en = 1'b1;
      cfg_in = cfg_b[i];
    end
    @(negedge clk);
    cfg_en = 1'b0;
    cfg_in = 1'b0;
    #1;
    apply_and_check("R3 R2 streamed config", cfg_b, '1);
    apply_and_check("R3 R2 streamed config data", cfg_b, NT'(16'hC381));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule